// File: doc/BRIEF.md
# Memory-Backed Message Queue Controller

This block receives fixed-size messages from a network port and appends each one to a circular queue that lives in ordinary memory. Every message is eight data words long. The sender does not name a queue by index. It gives the address of the queue's control word, and the controller maps that address to one of its queue contexts. Each context holds the ring's base address, its limit in words, the write tail, the read head, the number of stored messages, a pending-message count and an interrupt policy.

For each accepted send, the controller checks that the ring has a free slot. It then writes the eight words at consecutive memory addresses starting at the tail, moves the tail forward by eight with wrap-around, and returns an acknowledge. It may also raise a one-cycle interrupt tagged with the queue index. A send that cannot be placed gets a negative acknowledge and leaves memory and the queue state untouched.

Software sets up the queues, drains them and clears their counters through a command port. It watches progress through a combinational read port. Each queue has one of three interrupt policies: interrupt on every message, never interrupt (software polls), or interrupt once a programmed number of messages has arrived.

Top module: `msgq_ctrl`

## Requirements
- R1: An accepted message produces exactly eight memory writes on consecutive cycles. Word k (bits k*DATA_W upward of the send bus) goes to address base + tail + k, for k from 0 to 7 in order. `ack_valid` pulses for one cycle two cycles after the last write.
- R2: Each accepted message advances the queue's tail offset by 8. When the advanced value reaches the limit, it becomes the advanced value minus the limit, so with limits that are multiples of 8 it returns to 0.
- R3: A send to a queue whose stored message count equals limit/8 (integer division) gets a one-cycle `nack_valid` and no `ack_valid`. It causes no memory write, and it leaves tail, head and count unchanged.
- R4: A send whose control-word address is not CW_BASE + (i << CW_SHIFT) for some queue i below NQ gets `nack_valid` and causes no memory write.
- R5: Mode code 0 (every message) raises `irq_valid` in the same cycle as the acknowledge of every accepted message, with `irq_queue` set to the queue index. `irq_valid` never appears without `ack_valid`.
- R6: Mode code 1 (polling) never raises `irq_valid`, and the pending count stays 0. Mode code 3 behaves the same way. Arrivals are seen through `rd_tail` and `rd_fill`.
- R7: Mode code 2 (threshold) counts accepted messages in the pending count. The message that brings the count to the threshold raises `irq_valid` and resets the count to 0. A threshold of 0 acts as 1.
- R8: Command code 2 (clear) on `sw_op` resets the selected queue's pending count to 0, so the next threshold interrupt needs a full threshold of new messages.
- R9: Command code 1 (consume) with count n, when n does not exceed the stored count, advances the head by 8n words (modulo the limit) and lowers the stored count by n. When n exceeds the stored count, the command has no effect.
- R10: Command code 0 (configure) loads base, limit, threshold and mode into the selected queue and resets its tail, head, stored count and pending count to 0.
- R11: After reset, every queue has limit 0 and polling mode, so every send is negatively acknowledged. `ack_valid`, `nack_valid`, `irq_valid` and `mem_we` are low, and `send_ready` is high.
- R12: While a send is in progress, `send_ready` is low and `send_valid` is ignored. A send presented then causes no writes and no change to any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_valid | input | 1 | Network presents a message |
| send_ready | output | 1 | Controller idle; a send is taken this cycle |
| send_cw_addr | input | ADDR_W | Control-word address naming the target queue |
| send_msg | input | 8*DATA_W | Eight message words, word 0 in the low bits |
| ack_valid | output | 1 | Message stored |
| nack_valid | output | 1 | Message rejected |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| irq_valid | output | 1 | Interrupt pulse |
| irq_queue | output | QW | Queue that raised the interrupt |
| sw_valid | input | 1 | Software command strobe |
| sw_op | input | 2 | 0 configure, 1 consume, 2 clear pending, 3 none |
| sw_queue | input | QW | Queue addressed by the command |
| sw_base | input | ADDR_W | Ring base address for configure |
| sw_limit | input | LIM_W | Ring size in words for configure |
| sw_thresh | input | THR_W | Interrupt threshold for configure |
| sw_mode | input | 2 | Interrupt mode for configure |
| sw_count | input | CNT_W | Messages consumed |
| rd_queue | input | QW | Queue shown on the read port |
| rd_tail | output | LIM_W | Tail offset |
| rd_head | output | LIM_W | Head offset |
| rd_fill | output | CNT_W | Stored message count |
| rd_pend | output | THR_W | Pending count |

## Verification
The bench builds the controller with NQ=3, 32-bit words, CW_BASE=0x100 and CW_SHIFT=4. With three queues, the next aligned address 0x130 looks valid but matches no queue, and 0x108 is misaligned, so both rejection paths of the decoder are reached. The bench configures rings of 16 to 64 words, which hold 2 to 8 messages. With rings that small, wrap-around and full-queue rejection happen within a few sends. Thresholds of 0 to 4 exercise the threshold interrupt and the clear command many times during the random phase.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    localparam int ADDR_W    = 32;
    localparam int LIM_W     = 25;
    localparam int THR_W     = 8;
    localparam int MSG_SHIFT = 3;
    localparam int MSG_WORDS = 1 << MSG_SHIFT;
    localparam int CNT_W     = LIM_W - MSG_SHIFT;

    typedef enum logic [1:0] {
        IRQ_EVERY = 2'd0,
        IRQ_POLL  = 2'd1,
        IRQ_COUNT = 2'd2,
        IRQ_RSVD  = 2'd3
    } irq_mode_e;

    typedef enum logic [1:0] {
        SW_CONFIG  = 2'd0,
        SW_CONSUME = 2'd1,
        SW_CLEAR   = 2'd2,
        SW_NONE    = 2'd3
    } sw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_COMMIT
    } fsm_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [THR_W-1:0]  thresh;
        irq_mode_e         mode;
    } qcfg_t;

    typedef struct packed {
        logic [LIM_W-1:0] tail;
        logic [LIM_W-1:0] head;
        logic [CNT_W-1:0] fill;
        logic [THR_W-1:0] pend;
    } qstate_t;

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [LIM_W-1:0] ring_add(
        logic [LIM_W-1:0] off,
        logic [LIM_W:0]   step,
        logic [LIM_W-1:0] lim
    );
        logic [LIM_W:0] s;
        s = {1'b0, off} + step;
        if (s >= {1'b0, lim}) s = s - {1'b0, lim};
        return s[LIM_W-1:0];
    endfunction

    function automatic logic [CNT_W-1:0] slots_of(logic [LIM_W-1:0] lim);
        return lim[LIM_W-1:MSG_SHIFT];
    endfunction

    function automatic logic [THR_W-1:0] eff_thresh(logic [THR_W-1:0] t);
        return (t == '0) ? THR_W'(1) : t;
    endfunction

endpackage

// File: rtl/msgq_cw_decode.sv
module msgq_cw_decode
    import msgq_pkg::*;
#(
    parameter int                NQ       = 4,
    parameter logic [ADDR_W-1:0] CW_BASE  = 32'h0000_1000,
    parameter int                CW_SHIFT = 3,
    localparam int               QW       = idx_w(NQ)
) (
    input  logic [ADDR_W-1:0] cw_addr,
    output logic              hit,
    output logic [QW-1:0]     qidx
);

    logic [NQ-1:0] match;

    for (genvar g = 0; g < NQ; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] SLOT = CW_BASE + (ADDR_W'(g) << CW_SHIFT);
        assign match[g] = (cw_addr == SLOT);
    end

    always_comb begin
        hit  = |match;
        qidx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (match[i]) qidx = QW'(i);
        end
    end

endmodule

// File: rtl/msgq_irq_policy.sv
module msgq_irq_policy
    import msgq_pkg::*;
(
    input  irq_mode_e        mode,
    input  logic [THR_W-1:0] thresh,
    input  logic [THR_W-1:0] pend,
    output logic             fire,
    output logic [THR_W-1:0] pend_next
);

    logic [THR_W:0] bumped;

    always_comb begin
        bumped    = {1'b0, pend} + (THR_W+1)'(1);
        fire      = 1'b0;
        pend_next = pend;
        unique case (mode)
            IRQ_EVERY: begin
                fire      = 1'b1;
                pend_next = '0;
            end
            IRQ_COUNT: begin
                if (bumped >= {1'b0, eff_thresh(thresh)}) begin
                    fire      = 1'b1;
                    pend_next = '0;
                end else begin
                    pend_next = bumped[THR_W-1:0];
                end
            end
            default: begin
                fire      = 1'b0;
                pend_next = pend;
            end
        endcase
    end

endmodule

// File: rtl/msgq_ctx_table.sv
module msgq_ctx_table
    import msgq_pkg::*;
#(
    parameter int  NQ = 4,
    localparam int QW = idx_w(NQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [QW-1:0]    cfg_q,
    input  qcfg_t            cfg_in,
    input  logic             cons_we,
    input  logic [QW-1:0]    cons_q,
    input  logic [CNT_W-1:0] cons_cnt,
    input  logic             clr_we,
    input  logic [QW-1:0]    clr_q,
    input  logic             cmt_we,
    input  logic [QW-1:0]    cmt_q,
    input  logic [THR_W-1:0] cmt_pend,
    output qcfg_t            cfg_o [NQ],
    output qstate_t          st_o  [NQ]
);

    localparam logic [LIM_W:0] STEP_MSG = (LIM_W+1)'(MSG_WORDS);

    for (genvar g = 0; g < NQ; g++) begin : g_q
        qcfg_t            cfg_r;
        qstate_t          st_r;
        logic             sel_cfg, sel_cmt, sel_cons, sel_clr, cons_ok;
        logic [CNT_W-1:0] fill_dec;

        always_comb begin
            sel_cfg  = cfg_we  && (cfg_q  == QW'(g));
            sel_cmt  = cmt_we  && (cmt_q  == QW'(g));
            sel_cons = cons_we && (cons_q == QW'(g));
            sel_clr  = clr_we  && (clr_q  == QW'(g));
            cons_ok  = sel_cons && (cons_cnt <= st_r.fill);
            fill_dec = cons_ok ? cons_cnt : '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_r.base   <= '0;
                cfg_r.limit  <= '0;
                cfg_r.thresh <= '0;
                cfg_r.mode   <= IRQ_POLL;
                st_r         <= '0;
            end else if (sel_cfg) begin
                cfg_r <= cfg_in;
                st_r  <= '0;
            end else begin
                if (sel_cmt)
                    st_r.tail <= ring_add(st_r.tail, STEP_MSG, cfg_r.limit);
                if (cons_ok)
                    st_r.head <= ring_add(st_r.head, {1'b0, cons_cnt, MSG_SHIFT'(0)}, cfg_r.limit);
                st_r.fill <= st_r.fill + CNT_W'(sel_cmt) - fill_dec;
                if (sel_clr)
                    st_r.pend <= '0;
                else if (sel_cmt)
                    st_r.pend <= cmt_pend;
            end
        end

        assign cfg_o[g] = cfg_r;
        assign st_o[g]  = st_r;

        AST_FILL_WITHIN_SLOTS: assert property (@(posedge clk) disable iff (rst)
            st_r.fill <= slots_of(cfg_r.limit)) else $error("fill above ring slots"); // R3
        AST_TAIL_IN_RING: assert property (@(posedge clk) disable iff (rst)
            (cfg_r.limit == '0) || (st_r.tail < cfg_r.limit)) else $error("tail outside ring"); // R2
        AST_PEND_BELOW_THR: assert property (@(posedge clk) disable iff (rst)
            (cfg_r.mode == IRQ_COUNT) |-> (st_r.pend < eff_thresh(cfg_r.thresh))) else $error("pending reached threshold"); // R7
    end

endmodule

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
    import msgq_pkg::*;
#(
    parameter int                NQ       = 4,
    parameter int                DATA_W   = 64,
    parameter logic [ADDR_W-1:0] CW_BASE  = 32'h0000_1000,
    parameter int                CW_SHIFT = 3,
    localparam int               QW       = idx_w(NQ)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          send_valid,
    output logic                          send_ready,
    input  logic [ADDR_W-1:0]             send_cw_addr,
    input  logic [MSG_WORDS*DATA_W-1:0]   send_msg,
    output logic                          ack_valid,
    output logic                          nack_valid,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    output logic                          irq_valid,
    output logic [QW-1:0]                 irq_queue,
    input  logic                          sw_valid,
    input  logic [1:0]                    sw_op,
    input  logic [QW-1:0]                 sw_queue,
    input  logic [ADDR_W-1:0]             sw_base,
    input  logic [LIM_W-1:0]              sw_limit,
    input  logic [THR_W-1:0]              sw_thresh,
    input  logic [1:0]                    sw_mode,
    input  logic [CNT_W-1:0]              sw_count,
    input  logic [QW-1:0]                 rd_queue,
    output logic [LIM_W-1:0]              rd_tail,
    output logic [LIM_W-1:0]              rd_head,
    output logic [CNT_W-1:0]              rd_fill,
    output logic [THR_W-1:0]              rd_pend
);

    fsm_e                state;
    logic [DATA_W-1:0]   msg_r [MSG_WORDS];
    logic [QW-1:0]       q_r;
    logic                hit_r;
    logic [MSG_SHIFT-1:0] beat;
    logic                ack_r, nack_r, irq_r;
    logic [QW-1:0]       irq_q_r;

    logic                dec_hit;
    logic [QW-1:0]       dec_q;
    qcfg_t               cfg_all [NQ];
    qstate_t             st_all  [NQ];
    qcfg_t               cur_cfg;
    qstate_t             cur_st;
    logic                fire;
    logic [THR_W-1:0]    pend_next;
    sw_op_e              op;
    qcfg_t               cfg_in;
    logic                room;

    msgq_cw_decode #(
        .NQ(NQ), .CW_BASE(CW_BASE), .CW_SHIFT(CW_SHIFT)
    ) u_decode (
        .cw_addr(send_cw_addr),
        .hit    (dec_hit),
        .qidx   (dec_q)
    );

    always_comb begin
        op            = sw_op_e'(sw_op);
        cfg_in.base   = sw_base;
        cfg_in.limit  = sw_limit;
        cfg_in.thresh = sw_thresh;
        cfg_in.mode   = irq_mode_e'(sw_mode);
    end

    msgq_ctx_table #(.NQ(NQ)) u_table (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (sw_valid && op == SW_CONFIG),
        .cfg_q   (sw_queue),
        .cfg_in  (cfg_in),
        .cons_we (sw_valid && op == SW_CONSUME),
        .cons_q  (sw_queue),
        .cons_cnt(sw_count),
        .clr_we  (sw_valid && op == SW_CLEAR),
        .clr_q   (sw_queue),
        .cmt_we  (state == ST_COMMIT),
        .cmt_q   (q_r),
        .cmt_pend(pend_next),
        .cfg_o   (cfg_all),
        .st_o    (st_all)
    );

    assign cur_cfg = cfg_all[q_r];
    assign cur_st  = st_all[q_r];
    assign room    = cur_st.fill < slots_of(cur_cfg.limit);

    msgq_irq_policy u_policy (
        .mode     (cur_cfg.mode),
        .thresh   (cur_cfg.thresh),
        .pend     (cur_st.pend),
        .fire     (fire),
        .pend_next(pend_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            q_r     <= '0;
            hit_r   <= 1'b0;
            beat    <= '0;
            ack_r   <= 1'b0;
            nack_r  <= 1'b0;
            irq_r   <= 1'b0;
            irq_q_r <= '0;
            for (int i = 0; i < MSG_WORDS; i++) msg_r[i] <= '0;
        end else begin
            ack_r  <= 1'b0;
            nack_r <= 1'b0;
            irq_r  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (send_valid) begin
                        for (int i = 0; i < MSG_WORDS; i++)
                            msg_r[i] <= send_msg[i*DATA_W +: DATA_W];
                        q_r   <= dec_q;
                        hit_r <= dec_hit;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (hit_r && room) begin
                        beat  <= '0;
                        state <= ST_WRITE;
                    end else begin
                        nack_r <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    beat <= beat + 1'b1;
                    if (beat == MSG_SHIFT'(MSG_WORDS - 1)) state <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    ack_r   <= 1'b1;
                    irq_r   <= fire;
                    irq_q_r <= q_r;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign send_ready = (state == ST_IDLE);
    assign ack_valid  = ack_r;
    assign nack_valid = nack_r;
    assign irq_valid  = irq_r;
    assign irq_queue  = irq_q_r;
    assign mem_we     = (state == ST_WRITE);
    assign mem_addr   = cur_cfg.base + ADDR_W'(cur_st.tail) + ADDR_W'(beat);
    assign mem_wdata  = msg_r[beat];

    always_comb begin
        if (int'(rd_queue) < NQ) begin
            rd_tail = st_all[rd_queue].tail;
            rd_head = st_all[rd_queue].head;
            rd_fill = st_all[rd_queue].fill;
            rd_pend = st_all[rd_queue].pend;
        end else begin
            rd_tail = '0;
            rd_head = '0;
            rd_fill = '0;
            rd_pend = '0;
        end
    end

    AST_ACK_AFTER_WRITES: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(mem_we, 2)) else $error("ack without preceding writes"); // R1
    AST_NACK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        nack_valid |-> (!ack_valid && !$past(mem_we))) else $error("nack alongside writes"); // R3
    AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ack_valid) else $error("irq without ack"); // R5
    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_addr - cur_cfg.base) < ADDR_W'(cur_cfg.limit))) else $error("write outside ring"); // R1
    AST_BUSY_HOLDS_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!send_ready && $past(!send_ready)) |-> $stable(q_r)) else $error("target changed while busy"); // R12

endmodule

// File: tb/msgq_ctrl_bench.sv
`timescale 1ns/1ps
module msgq_ctrl_bench;
    import msgq_pkg::*;

    localparam int NQ = 3;
    localparam int DW = 32;
    localparam int QW = idx_w(NQ);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                     send_valid = 1'b0;
    logic                     send_ready;
    logic [ADDR_W-1:0]        send_cw_addr = '0;
    logic [MSG_WORDS*DW-1:0]  send_msg = '0;
    logic                     ack_valid, nack_valid, mem_we, irq_valid;
    logic [ADDR_W-1:0]        mem_addr;
    logic [DW-1:0]            mem_wdata;
    logic [QW-1:0]            irq_queue;
    logic                     sw_valid = 1'b0;
    logic [1:0]               sw_op = 2'd3;
    logic [QW-1:0]            sw_queue = '0;
    logic [ADDR_W-1:0]        sw_base = '0;
    logic [LIM_W-1:0]         sw_limit = '0;
    logic [THR_W-1:0]         sw_thresh = '0;
    logic [1:0]               sw_mode = '0;
    logic [CNT_W-1:0]         sw_count = '0;
    logic [QW-1:0]            rd_queue = '0;
    logic [LIM_W-1:0]         rd_tail, rd_head;
    logic [CNT_W-1:0]         rd_fill;
    logic [THR_W-1:0]         rd_pend;

    msgq_ctrl #(.NQ(NQ), .DATA_W(DW), .CW_BASE(32'h0000_0100), .CW_SHIFT(4)) u_msgq_ctrl (
        .clk(clk), .rst(rst),
        .send_valid(send_valid), .send_ready(send_ready), .send_cw_addr(send_cw_addr),
        .send_msg(send_msg), .ack_valid(ack_valid), .nack_valid(nack_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .irq_valid(irq_valid), .irq_queue(irq_queue),
        .sw_valid(sw_valid), .sw_op(sw_op), .sw_queue(sw_queue), .sw_base(sw_base),
        .sw_limit(sw_limit), .sw_thresh(sw_thresh), .sw_mode(sw_mode), .sw_count(sw_count),
        .rd_queue(rd_queue), .rd_tail(rd_tail), .rd_head(rd_head), .rd_fill(rd_fill),
        .rd_pend(rd_pend)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    int m_base [NQ], m_lim [NQ], m_thr [NQ], m_mode [NQ];
    int m_tail [NQ], m_head [NQ], m_fill [NQ], m_pend [NQ];

    int          wcnt = 0;
    logic [31:0] w_addr [16];
    logic [31:0] w_data [16];

    always @(negedge clk) begin
        if (mem_we) begin
            if (wcnt < 16) begin
                w_addr[wcnt] = mem_addr;
                w_data[wcnt] = mem_wdata;
            end
            wcnt = wcnt + 1;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            nerr = nerr + 1;
            $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int q);
        return 32'h100 + 32'(q) * 32'd16;
    endfunction

    task automatic sw_do(input int op, input int q, input int base, input int lim,
                         input int thr, input int mode, input int cnt);
        @(negedge clk);
        sw_valid  = 1'b1;
        sw_op     = 2'(op);
        sw_queue  = QW'(q);
        sw_base   = 32'(base);
        sw_limit  = LIM_W'(lim);
        sw_thresh = THR_W'(thr);
        sw_mode   = 2'(mode);
        sw_count  = CNT_W'(cnt);
        @(negedge clk);
        sw_valid  = 1'b0;
        if (op == 0) begin
            m_base[q] = base; m_lim[q] = lim; m_thr[q] = thr; m_mode[q] = mode;
            m_tail[q] = 0; m_head[q] = 0; m_fill[q] = 0; m_pend[q] = 0;
        end else if (op == 1) begin
            if (cnt <= m_fill[q]) begin
                m_head[q] = (m_head[q] + 8 * cnt) % m_lim[q];
                m_fill[q] = m_fill[q] - cnt;
            end
        end else if (op == 2) begin
            m_pend[q] = 0;
        end
    endtask

    task automatic read_check(input int q, input string tag);
        @(negedge clk);
        rd_queue = QW'(q);
        #1;
        chk(int'(rd_tail) == m_tail[q], {tag, " tail"}, rd_tail, m_tail[q]);
        chk(int'(rd_head) == m_head[q], {tag, " head"}, rd_head, m_head[q]);
        chk(int'(rd_fill) == m_fill[q], {tag, " fill"}, rd_fill, m_fill[q]);
        chk(int'(rd_pend) == m_pend[q], {tag, " pend"}, rd_pend, m_pend[q]);
    endtask

    task automatic send_msg_to(input int q, input bit bad, input int poke);
        logic [31:0] addr;
        logic [31:0] exp_w [MSG_WORDS];
        bit          acc, exp_irq, seen;
        int          new_pend;
        string       tag;
        addr = bad ? (($urandom % 2) ? 32'h130 : 32'h108) : cw(q);
        acc  = !bad && (m_fill[q] < m_lim[q] / 8);
        tag  = acc ? "R1" : (bad ? "R4" : (m_lim[q] == 0 ? "R11" : "R3"));
        exp_irq  = 1'b0;
        new_pend = bad ? 0 : m_pend[q];
        if (acc) begin
            case (m_mode[q])
                0: begin exp_irq = 1'b1; new_pend = 0; end
                2: begin
                    if (m_pend[q] + 1 >= ((m_thr[q] == 0) ? 1 : m_thr[q])) begin
                        exp_irq = 1'b1; new_pend = 0;
                    end else new_pend = m_pend[q] + 1;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        for (int k = 0; k < MSG_WORDS; k++) begin
            exp_w[k] = $urandom;
            send_msg[k*DW +: DW] = exp_w[k];
        end
        send_cw_addr = addr;
        send_valid   = 1'b1;
        wcnt = 0;
        @(negedge clk);
        if (poke > 0) begin
            send_cw_addr = cw(1);
            for (int k = 0; k < MSG_WORDS; k++) send_msg[k*DW +: DW] = ~exp_w[k];
            chk(send_ready == 1'b0, "R12 ready low while busy", send_ready, 0);
            repeat (poke) @(negedge clk);
        end
        send_valid = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (ack_valid || nack_valid) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(seen, {tag, " response arrives"}, seen, 1);
        chk(ack_valid == acc, {tag, " ack"}, ack_valid, acc);
        chk(nack_valid == !acc, {tag, " nack"}, nack_valid, !acc);
        chk(irq_valid == exp_irq, exp_irq ? "R5/R7 irq raised" : "R6/R7 irq absent", irq_valid, exp_irq);
        if (exp_irq) chk(int'(irq_queue) == q, "R5 irq queue", irq_queue, q);
        if (acc) begin
            chk(wcnt == MSG_WORDS, "R1 write count", wcnt, MSG_WORDS);
            for (int k = 0; k < MSG_WORDS && k < wcnt; k++) begin
                chk(w_addr[k] == 32'(m_base[q] + m_tail[q] + k), "R1 write address", w_addr[k], m_base[q] + m_tail[q] + k);
                chk(w_data[k] == exp_w[k], "R1 write data", w_data[k], exp_w[k]);
            end
            m_tail[q] = m_tail[q] + 8;
            if (m_tail[q] >= m_lim[q]) m_tail[q] = m_tail[q] - m_lim[q];
            m_fill[q] = m_fill[q] + 1;
            m_pend[q] = new_pend;
        end else begin
            chk(wcnt == 0, {tag, " no write on reject"}, wcnt, 0);
        end
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd4242);
        for (int q = 0; q < NQ; q++) begin
            m_base[q] = 0; m_lim[q] = 0; m_thr[q] = 0; m_mode[q] = 1;
            m_tail[q] = 0; m_head[q] = 0; m_fill[q] = 0; m_pend[q] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(send_ready == 1'b1, "R11 ready after reset", send_ready, 1);
        chk(!ack_valid && !nack_valid, "R11 ack/nack low", {ack_valid, nack_valid}, 0);
        chk(!irq_valid && !mem_we, "R11 irq/we low", {irq_valid, mem_we}, 0);
        read_check(0, "R11");
        send_msg_to(0, 1'b0, 0);

        sw_do(0, 0, 32'h1000, 32, 0, 0, 0);
        sw_do(0, 1, 32'h2000, 24, 0, 1, 0);
        sw_do(0, 2, 32'h3000, 64, 3, 2, 0);
        read_check(0, "R10");

        for (int i = 0; i < 4; i++) send_msg_to(0, 1'b0, 0);
        read_check(0, "R2 wrap");
        send_msg_to(0, 1'b0, 0);
        read_check(0, "R3 full unchanged");
        sw_do(1, 0, 0, 0, 0, 0, 2);
        read_check(0, "R9 consume");
        sw_do(1, 0, 0, 0, 0, 0, 5);
        read_check(0, "R9 over-consume ignored");
        send_msg_to(0, 1'b0, 0);
        send_msg_to(0, 1'b0, 0);
        read_check(0, "R2 after wrap");

        send_msg_to(0, 1'b1, 0);
        send_msg_to(2, 1'b1, 0);

        for (int i = 0; i < 4; i++) send_msg_to(1, 1'b0, 0);
        read_check(1, "R6 polling");

        for (int i = 0; i < 6; i++) send_msg_to(2, 1'b0, 0);
        send_msg_to(2, 1'b0, 0);
        send_msg_to(2, 1'b0, 0);
        read_check(2, "R7 pending");
        sw_do(2, 2, 0, 0, 0, 0, 0);
        read_check(2, "R8 clear");
        for (int i = 0; i < 3; i++) send_msg_to(2, 1'b0, 0);
        sw_do(0, 2, 32'h3000, 64, 0, 2, 0);
        send_msg_to(2, 1'b0, 0);
        send_msg_to(2, 1'b0, 0);

        sw_do(1, 0, 0, 0, 0, 0, 1);
        send_msg_to(0, 1'b0, 3);
        read_check(1, "R12 busy send ignored");
        read_check(0, "R12 target intact");

        sw_do(0, 0, 32'h1000, 40, 2, 2, 0);
        read_check(0, "R10 reconfigure");

        for (int it = 0; it < 500; it++) begin
            int r, q;
            r = int'($urandom % 20);
            q = int'($urandom % NQ);
            if (r < 11) begin
                send_msg_to(q, ($urandom % 8) == 0, 0);
            end else if (r < 15) begin
                if (m_lim[q] > 0) sw_do(1, q, 0, 0, 0, 0, int'($urandom % (m_fill[q] + 2)));
            end else if (r < 17) begin
                sw_do(2, q, 0, 0, 0, 0, 0);
            end else if (r < 19) begin
                read_check(q, "R9 random state");
            end else begin
                int lims [5] = '{16, 24, 32, 40, 64};
                sw_do(0, q, 32'h10000 * (q + 1), lims[$urandom % 5], int'($urandom % 5), int'($urandom % 4), 0);
            end
        end
        for (int q = 0; q < NQ; q++) read_check(q, "R2 final state");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule